// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block carries out stack-based control-transfer and frame operations one command at a time, against a small word-wide stack memory of its own. It holds four architectural registers: a 32-bit stack pointer, a 32-bit instruction pointer, a 16-bit code segment and a 32-bit frame base pointer. The stack grows toward lower byte addresses, and every slot is one 32-bit word, so the stack pointer moves in steps of 4.

A command is an operation code with its operands: a 32-bit data/target word, a 16-bit target segment and a 16-bit discard byte count. It is accepted on a valid/ready handshake. The sequencer then walks through one state per memory access or register move. It never makes more than one memory access per cycle, and it pulses `done` for one cycle when the registers hold the final result. Popped plain data appears on `pop_data`.

The states are ST_IDLE (ready, waiting), ST_WR_A (first push slot), ST_WR_B (second push slot, far call only), ST_RD_A (first pop), ST_RD_B (second pop, far return only), ST_ADJ (add the discard count), ST_MOVE (stack pointer takes the base pointer) and ST_SETBP (base pointer takes the stack pointer). The transitions are as follows:
- ST_IDLE→ST_WR_A for push, near call, far call and enter.
- ST_IDLE→ST_RD_A for pop, near return and far return.
- ST_IDLE→ST_MOVE for leave.
- ST_WR_A→ST_WR_B for a far call, ST_WR_A→ST_SETBP for enter, and ST_WR_A→ST_IDLE otherwise.
- ST_WR_B→ST_IDLE.
- ST_RD_A→ST_ADJ for a near return, ST_RD_A→ST_RD_B for a far return, and ST_RD_A→ST_IDLE otherwise.
- ST_RD_B→ST_ADJ.
- ST_ADJ→ST_IDLE.
- ST_MOVE→ST_RD_A.
- ST_SETBP→ST_IDLE.

Top module: `call_stack_seq`

## Requirements
- R1: After synchronous reset, the stack pointer equals parameter TOS and the instruction pointer, code segment and base pointer are 0. `cmd_ready` is 1 and `done` is 0.
- R2: Push (op code 0) lowers the stack pointer by 4, then stores `cmd_data` in the slot at the new stack pointer.
- R3: Pop (op code 1) places the word at the stack pointer on `pop_data`, then raises the stack pointer by 4.
- R4: Near call (op code 2) pushes the current instruction pointer, then loads `cmd_data` into the instruction pointer.
- R5: Near return (op code 3) pops the instruction pointer, then adds the zero-extended `cmd_cnt` to the stack pointer.
- R6: Far call (op code 4) first pushes the code segment, zero-extended to 32 bits, and then the instruction pointer. It then loads `cmd_seg` into the code segment and `cmd_data` into the instruction pointer. The net change to the stack pointer is −8.
- R7: Far return (op code 5) pops the instruction pointer first and then the code segment (low 16 bits of the word). It then adds `cmd_cnt` to the stack pointer.
- R8: Enter (op code 6) pushes the base pointer, then copies the new stack pointer into the base pointer.
- R9: Leave (op code 7) copies the base pointer into the stack pointer, then pops the base pointer.
- R10: `cmd_ready` is 1 only in ST_IDLE. A command is taken when `cmd_valid` and `cmd_ready` are both 1. `cmd_valid` asserted while the sequencer is busy has no effect.
- R11: `done` is a single-cycle pulse that arrives while the block is idle again. It comes this many cycles after the accepting edge: 1 for push, pop and near call; 2 for near return, far call, enter and leave; 3 for far return.
- R12: A slot's memory word index is stack pointer bits [log2(DEPTH)+1:2]. Addresses therefore wrap modulo DEPTH words, and the stack pointer wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 3 | Operation code (0 push … 7 leave) |
| cmd_data | input | 32 | Push operand or call target offset |
| cmd_seg | input | 16 | Far call target segment |
| cmd_cnt | input | 16 | Return discard byte count |
| done | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Stack pointer |
| ip_o | output | 32 | Instruction pointer |
| cs_o | output | 16 | Code segment |
| bp_o | output | 32 | Base pointer |
| pop_data | output | 32 | Word read by the last pop |

## Verification
The bench builds the block with DEPTH = 8 and TOS = 32, so the empty stack sits exactly at the top of an eight-word memory. With this setting, nine pushes carry the stack pointer below zero to 0xFFFFFFFC and make the ninth slot land on the first one. This exercises the wrap in R12 without a long run. The small top value also keeps every expected pointer a short, hand-checkable number, so nested far calls, parameter discards and two-level frames can all be traced slot by slot.

// File: rtl/css_pkg.sv
package css_pkg;
    typedef enum logic [2:0] {
        OP_PUSH   = 3'd0,
        OP_POP    = 3'd1,
        OP_CALL_N = 3'd2,
        OP_RET_N  = 3'd3,
        OP_CALL_F = 3'd4,
        OP_RET_F  = 3'd5,
        OP_ENTER  = 3'd6,
        OP_LEAVE  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_A,
        ST_WR_B,
        ST_RD_A,
        ST_RD_B,
        ST_ADJ,
        ST_MOVE,
        ST_SETBP
    } st_e;
endpackage

// File: rtl/css_stack_mem.sv
module css_stack_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/css_seq.sv
module css_seq
    import css_pkg::*;
#(
    parameter int          DEPTH = 64,
    parameter logic [31:0] TOS   = 32'd256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [31:0]   cmd_data,
    input  logic [15:0]   cmd_seg,
    input  logic [15:0]   cmd_cnt,
    output logic          done,
    output logic [31:0]   sp_o,
    output logic [31:0]   ip_o,
    output logic [15:0]   cs_o,
    output logic [31:0]   bp_o,
    output logic [31:0]   pop_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);
    st_e         state, nxt;
    op_e         op_q;
    logic [31:0] sp_q, ip_q, bp_q, data_q, pop_q;
    logic [15:0] cs_q, seg_q, cnt_q;
    logic        done_q;
    logic [31:0] sp_dec, sp_inc;

    assign sp_dec = sp_q - 32'd4;
    assign sp_inc = sp_q + 32'd4;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (op_e'(cmd_op))
                        OP_POP, OP_RET_N, OP_RET_F: nxt = ST_RD_A;
                        OP_LEAVE:                   nxt = ST_MOVE;
                        default:                    nxt = ST_WR_A;
                    endcase
                end
            end
            ST_WR_A: begin
                case (op_q)
                    OP_CALL_F: nxt = ST_WR_B;
                    OP_ENTER:  nxt = ST_SETBP;
                    default:   nxt = ST_IDLE;
                endcase
            end
            ST_WR_B:  nxt = ST_IDLE;
            ST_RD_A: begin
                case (op_q)
                    OP_RET_N: nxt = ST_ADJ;
                    OP_RET_F: nxt = ST_RD_B;
                    default:  nxt = ST_IDLE;
                endcase
            end
            ST_RD_B:  nxt = ST_ADJ;
            ST_ADJ:   nxt = ST_IDLE;
            ST_MOVE:  nxt = ST_RD_A;
            ST_SETBP: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // memory port drive
    always_comb begin
        mem_we    = (state == ST_WR_A) || (state == ST_WR_B);
        mem_addr  = mem_we ? sp_dec[AW+1:2] : sp_q[AW+1:2];
        mem_wdata = ip_q;
        if (state == ST_WR_A) begin
            case (op_q)
                OP_PUSH:   mem_wdata = data_q;
                OP_CALL_F: mem_wdata = {16'h0000, cs_q};
                OP_ENTER:  mem_wdata = bp_q;
                default:   mem_wdata = ip_q;
            endcase
        end
    end

    // registers and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= TOS;
            ip_q   <= '0;
            cs_q   <= '0;
            bp_q   <= '0;
            pop_q  <= '0;
            op_q   <= OP_PUSH;
            data_q <= '0;
            seg_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state != ST_IDLE) && (nxt == ST_IDLE);
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q   <= op_e'(cmd_op);
                        data_q <= cmd_data;
                        seg_q  <= cmd_seg;
                        cnt_q  <= cmd_cnt;
                    end
                end
                ST_WR_A: begin
                    sp_q <= sp_dec;
                    if (op_q == OP_CALL_N) ip_q <= data_q;
                end
                ST_WR_B: begin
                    sp_q <= sp_dec;
                    ip_q <= data_q;
                    cs_q <= seg_q;
                end
                ST_RD_A: begin
                    sp_q <= sp_inc;
                    case (op_q)
                        OP_POP:   pop_q <= mem_rdata;
                        OP_LEAVE: bp_q  <= mem_rdata;
                        default:  ip_q  <= mem_rdata;
                    endcase
                end
                ST_RD_B: begin
                    sp_q <= sp_inc;
                    cs_q <= mem_rdata[15:0];
                end
                ST_ADJ:   sp_q <= sp_q + {16'h0000, cnt_q};
                ST_MOVE:  sp_q <= bp_q;
                ST_SETBP: bp_q <= sp_q;
            endcase
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign done      = done_q;
    assign sp_o      = sp_q;
    assign ip_o      = ip_q;
    assign cs_o      = cs_q;
    assign bp_o      = bp_q;
    assign pop_data  = pop_q;
endmodule

// File: rtl/call_stack_seq.sv
module call_stack_seq #(
    parameter int          DEPTH = 64,
    parameter logic [31:0] TOS   = 32'd256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [2:0]  cmd_op,
    input  logic [31:0] cmd_data,
    input  logic [15:0] cmd_seg,
    input  logic [15:0] cmd_cnt,
    output logic        done,
    output logic [31:0] sp_o,
    output logic [31:0] ip_o,
    output logic [15:0] cs_o,
    output logic [31:0] bp_o,
    output logic [31:0] pop_data
);
    localparam int AW = $clog2(DEPTH);

    logic          m_we;
    logic [AW-1:0] m_addr;
    logic [31:0]   m_wdata, m_rdata;

    css_seq #(.DEPTH(DEPTH), .TOS(TOS)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_seg(cmd_seg), .cmd_cnt(cmd_cnt),
        .done(done), .sp_o(sp_o), .ip_o(ip_o), .cs_o(cs_o), .bp_o(bp_o),
        .pop_data(pop_data),
        .mem_we(m_we), .mem_addr(m_addr), .mem_wdata(m_wdata), .mem_rdata(m_rdata)
    );

    css_stack_mem #(.DEPTH(DEPTH), .W(32)) u_mem (
        .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata)
    );
endmodule

// File: rtl/css_chk.sv
module css_chk
    import css_pkg::*;
#(
    parameter logic [31:0] TOS = 32'd256
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [2:0]  cmd_op,
    input logic [31:0] cmd_data,
    input logic        done,
    input logic [31:0] sp_o,
    input logic [31:0] ip_o
);
    logic take;
    assign take = cmd_valid && cmd_ready;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sp_o == TOS) && (ip_o == 32'd0) && cmd_ready && !done);

    a_r10_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        take |=> !cmd_ready);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);

    a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
        take && (cmd_op == OP_PUSH) |-> ##2 (sp_o == $past(sp_o, 2) - 32'd4));

    a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
        take && (cmd_op == OP_POP) |-> ##2 (sp_o == $past(sp_o, 2) + 32'd4));

    a_r4_call_target: assert property (@(posedge clk) disable iff (rst)
        take && (cmd_op == OP_CALL_N) |-> ##2 (ip_o == $past(cmd_data, 2)));
endmodule

bind call_stack_seq css_chk #(.TOS(TOS)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .done(done),
    .sp_o(sp_o), .ip_o(ip_o)
);

// File: tb/call_stack_seq_tb.sv
module call_stack_seq_tb;
    localparam int          DEPTH = 8;
    localparam logic [31:0] TOS   = 32'd32;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_data;
    logic [15:0] cmd_seg;
    logic [15:0] cmd_cnt;
    logic        done;
    logic [31:0] sp_o, ip_o, bp_o, pop_data;
    logic [15:0] cs_o;

    int n_tests = 0;
    int n_fail  = 0;
    int lat;

    always #4 clk = ~clk;

    call_stack_seq #(.DEPTH(DEPTH), .TOS(TOS)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_seg(cmd_seg), .cmd_cnt(cmd_cnt),
        .done(done), .sp_o(sp_o), .ip_o(ip_o), .cs_o(cs_o), .bp_o(bp_o),
        .pop_data(pop_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [31:0] d,
                           input logic [15:0] seg, input logic [15:0] cnt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_seg = seg; cmd_cnt = cnt;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        chk("R1 sp", sp_o, TOS);
        chk("R1 ip", ip_o, 0);
        chk("R1 cs", {16'h0, cs_o}, 0);
        chk("R1 bp", bp_o, 0);
        chk("R1 ready", {31'h0, cmd_ready}, 1);
        chk("R1 done", {31'h0, done}, 0);
    endtask

    task automatic t_push_pop();
        run_cmd(3'd0, 32'hA1A1_0001, 16'h0, 16'h0);
        chk("R11 push latency", lat, 1);
        chk("R2 push sp", sp_o, 32'd28);
        @(negedge clk);
        chk("R11 done one cycle", {31'h0, done}, 0);
        run_cmd(3'd0, 32'hA2A2_0002, 16'h0, 16'h0);
        chk("R2 second push sp", sp_o, 32'd24);
        run_cmd(3'd1, 32'h0, 16'h0, 16'h0);
        chk("R11 pop latency", lat, 1);
        chk("R3 pop data top", pop_data, 32'hA2A2_0002);
        chk("R3 pop sp", sp_o, 32'd28);
        run_cmd(3'd1, 32'h0, 16'h0, 16'h0);
        chk("R3 pop data next", pop_data, 32'hA1A1_0001);
        chk("R3 pop sp back", sp_o, 32'd32);
    endtask

    task automatic t_near();
        run_cmd(3'd2, 32'h100, 16'h0, 16'h0);
        chk("R11 near call latency", lat, 1);
        chk("R4 call ip", ip_o, 32'h100);
        chk("R4 call sp", sp_o, 32'd28);
        run_cmd(3'd0, 32'h5555, 16'h0, 16'h0);
        run_cmd(3'd2, 32'h300, 16'h0, 16'h0);
        chk("R4 nested call ip", ip_o, 32'h300);
        chk("R4 nested call sp", sp_o, 32'd20);
        run_cmd(3'd3, 32'h0, 16'h0, 16'd4);
        chk("R11 near return latency", lat, 2);
        chk("R5 return ip", ip_o, 32'h100);
        chk("R5 return discard sp", sp_o, 32'd28);
        run_cmd(3'd3, 32'h0, 16'h0, 16'd0);
        chk("R5 return ip outer", ip_o, 32'h0);
        chk("R5 return sp outer", sp_o, 32'd32);
    endtask

    task automatic t_far();
        run_cmd(3'd4, 32'h4000, 16'h1234, 16'h0);
        chk("R11 far call latency", lat, 2);
        chk("R6 far call ip", ip_o, 32'h4000);
        chk("R6 far call cs", {16'h0, cs_o}, 32'h1234);
        chk("R6 far call sp", sp_o, 32'd24);
        run_cmd(3'd4, 32'h8000, 16'hBEEF, 16'h0);
        chk("R6 nested far sp", sp_o, 32'd16);
        run_cmd(3'd5, 32'h0, 16'h0, 16'h0);
        chk("R11 far return latency", lat, 3);
        chk("R7 far return ip", ip_o, 32'h4000);
        chk("R7 far return cs", {16'h0, cs_o}, 32'h1234);
        chk("R7 far return sp", sp_o, 32'd24);
        run_cmd(3'd5, 32'h0, 16'h0, 16'h0);
        chk("R7 outer return cs", {16'h0, cs_o}, 0);
        chk("R7 outer return sp", sp_o, 32'd32);
        // push order and zero extension, seen through pops
        run_cmd(3'd0, 32'hC0DE_0001, 16'h0, 16'h0);
        run_cmd(3'd4, 32'h10, 16'h00AB, 16'h0);
        run_cmd(3'd4, 32'h20, 16'hBEEF, 16'h0);
        run_cmd(3'd1, 32'h0, 16'h0, 16'h0);
        chk("R6 ip pushed last", pop_data, 32'h10);
        run_cmd(3'd1, 32'h0, 16'h0, 16'h0);
        chk("R6 cs pushed first zero-extended", pop_data, 32'h0000_00AB);
        run_cmd(3'd5, 32'h0, 16'h0, 16'd4);
        chk("R7 discard ip", ip_o, 32'h0);
        chk("R7 discard cs", {16'h0, cs_o}, 0);
        chk("R7 discard sp", sp_o, 32'd32);
    endtask

    task automatic t_frame();
        run_cmd(3'd6, 32'h0, 16'h0, 16'h0);
        chk("R11 enter latency", lat, 2);
        chk("R8 enter sp", sp_o, 32'd28);
        chk("R8 enter bp", bp_o, 32'd28);
        run_cmd(3'd0, 32'h1111, 16'h0, 16'h0);
        run_cmd(3'd6, 32'h0, 16'h0, 16'h0);
        chk("R8 inner bp", bp_o, 32'd20);
        run_cmd(3'd0, 32'h2222, 16'h0, 16'h0);
        run_cmd(3'd7, 32'h0, 16'h0, 16'h0);
        chk("R11 leave latency", lat, 2);
        chk("R9 leave bp", bp_o, 32'd28);
        chk("R9 leave sp", sp_o, 32'd24);
        run_cmd(3'd7, 32'h0, 16'h0, 16'h0);
        chk("R9 outer leave bp", bp_o, 32'd0);
        chk("R9 outer leave sp", sp_o, 32'd32);
    endtask

    task automatic t_busy();
        run_cmd(3'd0, 32'h7777_0007, 16'h0, 16'h0);
        run_cmd(3'd4, 32'h99, 16'h0077, 16'h0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_cnt = 16'd0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 ready low busy", {31'h0, cmd_ready}, 0);
        cmd_op = 3'd0; cmd_data = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        chk("R10 ready low busy 2", {31'h0, cmd_ready}, 0);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R11 done after far return", {31'h0, done}, 1);
        chk("R10 busy command ignored sp", sp_o, 32'd28);
        chk("R7 busy return ip", ip_o, 32'h0);
        run_cmd(3'd1, 32'h0, 16'h0, 16'h0);
        chk("R10 busy push not stored", pop_data, 32'h7777_0007);
        chk("R10 sp restored", sp_o, 32'd32);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 9; i++) run_cmd(3'd0, 32'h100 + i, 16'h0, 16'h0);
        chk("R12 sp wraps below zero", sp_o, 32'hFFFF_FFFC);
        for (int i = 0; i < 8; i++) begin
            run_cmd(3'd1, 32'h0, 16'h0, 16'h0);
            if (i == 0) chk("R12 top after wrap", pop_data, 32'h108);
            if (i == 7) chk("R12 eighth pop", pop_data, 32'h101);
        end
        run_cmd(3'd1, 32'h0, 16'h0, 16'h0);
        chk("R12 ninth slot aliases first", pop_data, 32'h108);
        chk("R12 sp back at top", sp_o, TOS);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0;
        cmd_data = '0; cmd_seg = '0; cmd_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_near();
        t_far();
        t_frame();
        t_busy();
        t_wrap();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule